// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block guards a system against runaway software. A 16-bit counter advances on each cycle in which the tick input is high. A 2-bit code selects one of four periods. When the counter reaches the selected period and the block is in watchdog mode, it sends a one-cycle system reset request. In interval mode the same event raises an interrupt and does not reset.

Software reaches the block through a small register port with two addresses. A control write is accepted only when it carries the right key in its upper byte. Any control write with another key is taken as a fault, and the block requests a reset at once. A sticky cause flag records every overflow and every key fault. The flag keeps its value through the reset that the block requests, so software can find out after a restart why the restart happened.

The reset request is fed back into the block as its own system reset. That returns the control byte and the counter to zero and leaves the cause flag alone. Only the active-low power-on reset clears the whole block.

Top module: `keyed_wdt`

## Requirements
- R1: After power-on reset (rst_ni low), a control read (addr_i=0) returns 0x6900, a flag read (addr_i=1) returns 0x0000, and sys_rst_o and irq_o are low.
- R2: A control write whose upper byte is 0x5A stores the lower byte. A control read returns 0x69 in bits [15:8] and the stored byte in bits [7:0], and bit 3 always reads as 0.
- R3: A control write whose upper byte is not 0x5A leaves the control byte unchanged, drives sys_rst_o high in the next cycle, and sets the cause flag.
- R4: Control bits [1:0] choose the period in ticks: 3 gives 64, 2 gives 512, 1 gives 8192, 0 gives 32768. An overflow fires on the tick at which the low log2(period) bits of the counter wrap to zero, and never on an earlier tick.
- R5: In watchdog mode (control bit 4 = 0), the overflow tick drives sys_rst_o high in the following cycle and sets the cause flag.
- R6: In interval mode (control bit 4 = 1), an overflow sets the cause flag and raises irq_o, and sys_rst_o stays low. The counter keeps running, so the next overflow comes one period later.
- R7: A keyed control write with bit 3 set clears the counter to zero, and the full period must then pass again before an overflow.
- R8: While control bit 7 is 1, ticks are ignored and the counter keeps its value. Counting resumes from that value when the bit is cleared.
- R9: In the cycle after a sys_rst_o pulse, the control byte and the counter are zero and the cause flag is still set.
- R10: A write to addr_i=1 with bit 0 = 0 clears the cause flag, and irq_o falls with it. A write with bit 0 = 1 has no effect on the flag.
- R11: sys_rst_o is high for exactly one cycle per fault. Bus writes made in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | Count enable, one counter step per high cycle |
| sel_i | input | 1 | Register port select |
| wr_i | input | 1 | Write strobe, valid with sel_i |
| addr_i | input | 1 | 0 = control register, 1 = cause flag register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i, combinational |
| sys_rst_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Interval interrupt request |

## Verification
The hardest case to reach is a reset that the block requests while the cause flag must survive it. The flag changes on the same edge that starts the pulse, and the control byte and counter clear on the edge after. The bench drives every period code to its overflow in both modes, holding the tick high for exactly one period. In each run it checks that the output stays quiet one tick early and fires on the final tick. Around each reset pulse it reads the control register and the flag, one cycle apart. Interval runs go on for a second period to show that the counter wraps and keeps counting. Hold and clear are each tested in the middle of a period, so that the remaining tick count is known.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int         CNT_W  = 16;
  localparam logic [7:0] WR_KEY = 8'h5A;
  localparam logic [7:0] RD_KEY = 8'h69;
  localparam int         B_CLR  = 3;
  localparam int         B_IVAL = 4;
  localparam int         B_HOLD = 7;
  localparam int         N_TAPS = 4;

  // log2 of the period for each select code
  function automatic int tap_bits(int code);
    case (code)
      3:       return 6;
      2:       return 9;
      1:       return 13;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        srst_i,
  input  logic        wr_en_i,
  input  logic [15:0] wdata_i,
  output logic [7:0]  ctrl_o,
  output logic        clr_o,
  output logic        bad_key_o
);
  localparam logic [7:0] KEEP_MASK = ~(8'(1) << B_CLR);

  logic [7:0] ctrl_q;
  logic       key_ok, upd;

  assign key_ok    = (wdata_i[15:8] == WR_KEY);
  assign upd       = wr_en_i & ~srst_i & key_ok;
  assign bad_key_o = wr_en_i & ~srst_i & ~key_ok;
  assign clr_o     = upd & wdata_i[B_CLR];
  assign ctrl_o    = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_q <= '0;
    else if (srst_i) ctrl_q <= '0;
    else if (upd)    ctrl_q <= wdata_i[7:0] & KEEP_MASK;
  end

  assert_badkey_keeps_ctrl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_key_o |=> $stable(ctrl_q));
  assert_srst_zero_ctrl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (ctrl_q == 8'h00));
  assert_no_write_in_srst_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_i && wr_en_i) |-> (!clr_o && !bad_key_o));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic       clr_i,
  input  logic [1:0] tap_sel_i,
  output logic       ovf_o
);
  logic [W-1:0]      cnt_q;
  logic [N_TAPS-1:0] low_full;
  logic              en;

  for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
    localparam int K = tap_bits(g);
    assign low_full[g] = &cnt_q[K-1:0];
  end

  assign en    = tick_i & ~hold_i & ~srst_i & ~clr_i;
  assign ovf_o = en & low_full[tap_sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (srst_i || clr_i) cnt_q <= '0;
    else if (en)              cnt_q <= cnt_q + 1'b1;
  end

  assert_hold_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !srst_i && !clr_i) |=> $stable(cnt_q));
  assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i || srst_i) |=> (cnt_q == '0));
  assert_ovf_needs_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (tick_i && !hold_i));
endmodule

// File: rtl/wdt_cause.sv
module wdt_cause (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_i,
  input  logic ival_i,
  input  logic bad_key_i,
  input  logic flag_wr_i,
  input  logic flag_bit_i,
  output logic sys_rst_o,
  output logic flag_o,
  output logic irq_o
);
  logic rst_q, flag_q, fault;

  assign fault     = ~rst_q & (bad_key_i | (ovf_i & ~ival_i));
  assign sys_rst_o = rst_q;
  assign flag_o    = flag_q;
  assign irq_o     = flag_q & ival_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      rst_q <= fault;
      if (!rst_q && (bad_key_i || ovf_i)) flag_q <= 1'b1;
      else if (!rst_q && flag_wr_i)       flag_q <= flag_q & flag_bit_i;
    end
  end

  assert_pulse_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |=> !rst_q);
  assert_flag_with_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_q |-> flag_q);
  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_wr_i) |=> flag_q);
  assert_ival_no_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && ival_i && !bad_key_i) |=> (!rst_q && flag_q));
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        sel_i,
  input  logic        wr_i,
  input  logic        addr_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        sys_rst_o,
  output logic        irq_o
);
  logic [7:0] ctrl;
  logic       clr, bad_key, ovf, flag, srst;
  logic       ctrl_wr, flag_wr;

  assign ctrl_wr   = sel_i & wr_i & ~addr_i;
  assign flag_wr   = sel_i & wr_i & addr_i;
  assign sys_rst_o = srst;

  wdt_ctrl_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst),
    .wr_en_i   (ctrl_wr),
    .wdata_i   (wdata_i),
    .ctrl_o    (ctrl),
    .clr_o     (clr),
    .bad_key_o (bad_key)
  );

  wdt_counter #(.W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst),
    .tick_i    (tick_i),
    .hold_i    (ctrl[B_HOLD]),
    .clr_i     (clr),
    .tap_sel_i (ctrl[1:0]),
    .ovf_o     (ovf)
  );

  wdt_cause u_cause (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ovf_i      (ovf),
    .ival_i     (ctrl[B_IVAL]),
    .bad_key_i  (bad_key),
    .flag_wr_i  (flag_wr),
    .flag_bit_i (wdata_i[0]),
    .sys_rst_o  (srst),
    .flag_o     (flag),
    .irq_o      (irq_o)
  );

  always_comb begin
    if (addr_i) rdata_o = {15'b0, flag};
    else        rdata_o = {RD_KEY, ctrl};
  end

  assert_badkey_resets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[15:8] != WR_KEY && !sys_rst_o) |=> sys_rst_o);
  assert_ctrl_bit3_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i |-> (rdata_o[B_CLR] == 1'b0));
endmodule

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        sel_i = 1'b0;
  logic        wr_i = 1'b0;
  logic        addr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        sys_rst_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  keyed_wdt u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .sel_i(sel_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .sys_rst_o(sys_rst_o), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    sel_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
  endtask

  // ticks n cycles; returns 1 if any output rose before the last tick
  task automatic run_ticks(input int n, output bit early);
    early = 1'b0;
    tick_i = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i < n - 1 && (sys_rst_o || irq_o)) early = 1'b1;
    end
    tick_i = 1'b0;
  endtask

  function automatic int period_of(int code);
    case (code)
      3: return 64;
      2: return 512;
      1: return 8192;
      default: return 32768;
    endcase
  endfunction

  initial begin
    logic [15:0] v;
    bit early;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(1'b0, v); chk("R1 ctrl", v, 16'h6900);
    rd(1'b1, v); chk("R1 flag", v, 16'h0000);
    chk("R1 outs", {14'b0, sys_rst_o, irq_o}, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 keyed writes and readback
    wr(1'b0, 16'h5AFF); rd(1'b0, v); chk("R2 ff", v, 16'h69F7);
    wr(1'b0, 16'h5A55); rd(1'b0, v); chk("R2 55", v, 16'h6955);
    wr(1'b0, 16'h5AAA); rd(1'b0, v); chk("R2 aa", v, 16'h69A2);
    wr(1'b0, 16'h5A00); rd(1'b0, v); chk("R2 00", v, 16'h6900);

    // R3 bad key
    wr(1'b0, 16'h5A13);
    wr(1'b0, 16'hDEAD);
    chk("R3 rst pulse", {15'b0, sys_rst_o}, 16'h0001);
    rd(1'b0, v); chk("R3 ctrl kept", v, 16'h6913);
    rd(1'b1, v); chk("R3 flag", v, 16'h0001);
    @(negedge clk);
    chk("R11 pulse end", {15'b0, sys_rst_o}, 16'h0000);
    rd(1'b0, v); chk("R9 ctrl zero", v, 16'h6900);
    wr(1'b1, 16'h0000);
    rd(1'b1, v); chk("R10 flag clr", v, 16'h0000);

    // R11 write during the pulse cycle is ignored
    wr(1'b0, 16'h1234);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = 1'b0; wdata_i = 16'h5A93;
    @(negedge clk);
    sel_i = 1'b0; wr_i = 1'b0; wdata_i = '0;
    chk("R11 single", {15'b0, sys_rst_o}, 16'h0000);
    rd(1'b0, v); chk("R11 write ignored", v, 16'h6900);
    wr(1'b1, 16'h0000);

    // R4/R5 watchdog sweep and R4/R6 interval sweep
    for (int md = 0; md < 2; md++) begin
      for (int code = 3; code >= 0; code--) begin
        int p;
        p = period_of(code);
        wr(1'b0, 16'h5A08 | 16'(md << 4) | 16'(code));
        run_ticks(p, early);
        chk($sformatf("R4 no early c%0d m%0d", code, md), {15'b0, early}, 16'h0000);
        if (md == 0) begin
          chk("R5 reset at period", {15'b0, sys_rst_o}, 16'h0001);
          rd(1'b1, v); chk("R5 flag", v, 16'h0001);
          @(negedge clk);
          chk("R11 one cycle", {15'b0, sys_rst_o}, 16'h0000);
          rd(1'b0, v); chk("R9 ctrl cleared", v, 16'h6900);
          rd(1'b1, v); chk("R9 flag survives", v, 16'h0001);
        end else begin
          chk("R6 irq", {14'b0, sys_rst_o, irq_o}, 16'h0001);
          wr(1'b1, 16'h0001);
          rd(1'b1, v); chk("R10 write 1 no effect", v, 16'h0001);
          wr(1'b1, 16'hFFFE);
          chk("R10 irq drops", {15'b0, irq_o}, 16'h0000);
          run_ticks(p, early);
          chk("R6 second period", {14'b0, early, irq_o}, 16'h0001);
        end
        wr(1'b1, 16'h0000);
      end
    end

    // R7 clear mid-period
    wr(1'b0, 16'h5A1B);
    run_ticks(50, early);
    wr(1'b0, 16'h5A1B);
    run_ticks(63, early);
    chk("R7 no irq after clear", {14'b0, early, irq_o}, 16'h0000);
    run_ticks(1, early);
    chk("R7 irq at full period", {15'b0, irq_o}, 16'h0001);
    wr(1'b1, 16'h0000);

    // R8 hold
    wr(1'b0, 16'h5A1B);
    run_ticks(40, early);
    wr(1'b0, 16'h5A93);
    run_ticks(200, early);
    chk("R8 held", {14'b0, early, irq_o}, 16'h0000);
    wr(1'b0, 16'h5A13);
    run_ticks(23, early);
    chk("R8 resume no early", {14'b0, early, irq_o}, 16'h0000);
    run_ticks(1, early);
    chk("R8 resume overflow", {15'b0, irq_o}, 16'h0001);

    // R1 power-on reset clears flag
    rst_ni = 1'b0;
    #1;
    rd(1'b1, v); chk("R1 flag por", v, 16'h0000);
    rd(1'b0, v); chk("R1 ctrl por", v, 16'h6900);
    rst_ni = 1'b1;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 190000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule